// File: doc/BRIEF.md
# Extended Translation Control Register

This block holds the 64-bit control word that steers stage-1 address translation for the lower privilege regime. A system-register move writes a new word through a single write port. The stored word is always available on a combinational read port. The translation logic receives a set of "effective" control lines. Each line is a stored field gated by whatever that field needs before it can take effect.

Every write is cleaned before it is stored, so the register never holds an illegal combination. Reserved positions are dropped. Fields whose feature is left out by a parameter are forced to zero. When the write selects the wide (128-bit) descriptor format, the wide-mode rules are applied. The two permission-overlay enables must never be cached in a TLB. For that reason, a one-cycle marker tells downstream logic that either of them has just changed, so that it can discard cached state.

Top module: `xlat_ctl2_reg`

## Requirements
- R1: Bit positions 63..16, 13, 12 and 9..6 always read 0. A write of 1 to them has no visible effect on the read port.
- R2: After the asynchronous active-low reset, the read port returns 0 and every effective output is 0.
- R3: A write stores its cleaned value at the clock edge, and the read port shows that value from the same edge. With no write, the read value holds.
- R4: Bit 5 selects the wide descriptor format (1 = wide). Its effective output follows the stored bit. It reads 0 when the wide feature is absent.
- R5: A write with bit 5 = 1 stores bit 4 (attribute-index enable) and bit 1 (indirect-permission select) as 1, whatever values the write carries for them.
- R6: A write with bit 5 = 1 stores bit 0 (protected-attribute enable) as 0. With bit 5 = 0, bit 0 is stored as written, and its effective output follows it.
- R7: Bit 15 (upper-range start table) and bit 14 (lower-range start table) suppress the contiguous hint. Their effective outputs are high only while the stored bit 5 is also 1.
- R8: The effective reduced-coherence output is the AND of stored bit 10 and the external permit input. It follows the permit input within the same cycle.
- R9: With the fixed-zero option for bit 10 selected, bit 10 always reads 0. Fields of absent features (wide: 15, 14, 5; overlay: 3, 2) read 0.
- R10: The overlay-change marker is high for exactly the one cycle after a write that changes stored bit 3 or bit 2. In every other cycle it is low.
- R11: Bit 11 (table access-flag hardware update), bit 3 (privileged overlay) and bit 2 (unprivileged overlay) are stored as written. Each drives its own effective output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe from the register move |
| wrData | input | 64 | Write value |
| hypCoherPermit | input | 1 | External permit for reduced-coherence writes |
| rdData | output | 64 | Stored (cleaned) value |
| effNoContigHi | output | 1 | Contiguous hint ignored, upper-range start table |
| effNoContigLo | output | 1 | Contiguous hint ignored, lower-range start table |
| effHwAccessTbl | output | 1 | Hardware access-flag update for table entries |
| effReducedCoher | output | 1 | Reduced-coherence writes permitted |
| effWideDesc | output | 1 | Wide descriptor format selected |
| effAttrIndex | output | 1 | Attribute indexing enabled |
| effOverlayPriv | output | 1 | Permission overlay, privileged accesses |
| effOverlayUnpriv | output | 1 | Permission overlay, unprivileged accesses |
| effIndirectPerm | output | 1 | Indirect permission model |
| effProtAttr | output | 1 | Descriptor bit 52 acts as protected attribute |
| overlayTouched | output | 1 | One-cycle marker of an overlay-enable change |

## Verification
The only internal state is the stored word and the marker flop. A wrong cleaning rule therefore shows on the read port on the first edge after the offending write, and it shows on the matching effective output in that same cycle. A missing or extra marker pulse shows one cycle after the write and nowhere else, so each write is paired with both its expected read value and its expected marker value. A second instance, with features removed and the fixed-zero option selected, shows that absent fields stay at zero.

// File: rtl/xctl_pkg.sv
package xctl_pkg;
  localparam int REG_W      = 64;
  localparam int POS_NCH_HI = 15;
  localparam int POS_NCH_LO = 14;
  localparam int POS_HWAF   = 11;
  localparam int POS_COHER  = 10;
  localparam int POS_WIDE   = 5;
  localparam int POS_ATTR   = 4;
  localparam int POS_OVL_P  = 3;
  localparam int POS_OVL_U  = 2;
  localparam int POS_INDIR  = 1;
  localparam int POS_PROT   = 0;

  typedef struct packed {
    logic load;     // capture a cleaned write this edge
    logic wideSel;  // the write selects the wide descriptor format
  } xctlStrobes_t;
endpackage

// File: rtl/xctl_ctrl.sv
module xctl_ctrl
  import xctl_pkg::*;
#(
  parameter bit HAS_WIDE = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         wideReq,
  input  logic [1:0]   curOvl,
  input  logic [1:0]   nextOvl,
  output xctlStrobes_t strb,
  output logic         overlayTouched
);
  always_comb begin
    strb.load    = wrEn;
    strb.wideSel = HAS_WIDE & wideReq;
  end

  // One-cycle marker: registered from a write that alters either overlay bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overlayTouched <= 1'b0;
    else       overlayTouched <= wrEn && (nextOvl != curOvl);
  end
endmodule

// File: rtl/xctl_datapath.sv
module xctl_datapath
  import xctl_pkg::*;
#(
  parameter bit HAS_WIDE         = 1'b1,
  parameter bit HAS_HWAF         = 1'b1,
  parameter bit HAS_COHER        = 1'b1,
  parameter bit COHER_FIXED_ZERO = 1'b0,
  parameter bit HAS_ATTR         = 1'b1,
  parameter bit HAS_OVERLAY      = 1'b1,
  parameter bit HAS_INDIR        = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  xctlStrobes_t     strb,
  input  logic [REG_W-1:0] wrData,
  input  logic             hypCoherPermit,
  output logic [REG_W-1:0] stored,
  output logic [1:0]       curOvl,
  output logic [1:0]       nextOvl,
  output logic             effNoContigHi,
  output logic             effNoContigLo,
  output logic             effHwAccessTbl,
  output logic             effReducedCoher,
  output logic             effWideDesc,
  output logic             effAttrIndex,
  output logic             effOverlayPriv,
  output logic             effOverlayUnpriv,
  output logic             effIndirectPerm,
  output logic             effProtAttr
);
  localparam bit COHER_RW = HAS_COHER & ~COHER_FIXED_ZERO;

  logic [REG_W-1:0] keepMask;
  logic [REG_W-1:0] forceMask;
  logic [REG_W-1:0] nextVal;

  // Keep-mask: positions copied from the write; force-mask: positions set to 1
  always_comb begin
    keepMask  = '0;
    forceMask = '0;
    keepMask[POS_NCH_HI] = HAS_WIDE;
    keepMask[POS_NCH_LO] = HAS_WIDE;
    keepMask[POS_WIDE]   = HAS_WIDE;
    keepMask[POS_HWAF]   = HAS_HWAF;
    keepMask[POS_COHER]  = COHER_RW;
    keepMask[POS_OVL_P]  = HAS_OVERLAY;
    keepMask[POS_OVL_U]  = HAS_OVERLAY;
    keepMask[POS_ATTR]   = HAS_ATTR  & ~strb.wideSel;
    keepMask[POS_INDIR]  = HAS_INDIR & ~strb.wideSel;
    keepMask[POS_PROT]   = HAS_COHER & ~strb.wideSel;
    forceMask[POS_ATTR]  = HAS_ATTR  & strb.wideSel;
    forceMask[POS_INDIR] = HAS_INDIR & strb.wideSel;
    nextVal = (wrData & keepMask) | forceMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          stored <= '0;
    else if (strb.load) stored <= nextVal;
  end

  assign curOvl  = {stored[POS_OVL_P], stored[POS_OVL_U]};
  assign nextOvl = {nextVal[POS_OVL_P], nextVal[POS_OVL_U]};

  assign effWideDesc      = stored[POS_WIDE];
  assign effNoContigHi    = stored[POS_NCH_HI] & stored[POS_WIDE];
  assign effNoContigLo    = stored[POS_NCH_LO] & stored[POS_WIDE];
  assign effHwAccessTbl   = stored[POS_HWAF];
  assign effAttrIndex     = stored[POS_ATTR];
  assign effOverlayPriv   = stored[POS_OVL_P];
  assign effOverlayUnpriv = stored[POS_OVL_U];
  assign effIndirectPerm  = stored[POS_INDIR];
  assign effProtAttr      = stored[POS_PROT];

  generate
    if (COHER_RW) begin : g_coher
      assign effReducedCoher = stored[POS_COHER] & hypCoherPermit;
    end else begin : g_no_coher
      logic unusedPermit;
      assign unusedPermit    = hypCoherPermit;
      assign effReducedCoher = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/xlat_ctl2_reg.sv
module xlat_ctl2_reg
  import xctl_pkg::*;
#(
  parameter bit HAS_WIDE         = 1'b1,
  parameter bit HAS_HWAF         = 1'b1,
  parameter bit HAS_COHER        = 1'b1,
  parameter bit COHER_FIXED_ZERO = 1'b0,
  parameter bit HAS_ATTR         = 1'b1,
  parameter bit HAS_OVERLAY      = 1'b1,
  parameter bit HAS_INDIR        = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [63:0] wrData,
  input  logic        hypCoherPermit,
  output logic [63:0] rdData,
  output logic        effNoContigHi,
  output logic        effNoContigLo,
  output logic        effHwAccessTbl,
  output logic        effReducedCoher,
  output logic        effWideDesc,
  output logic        effAttrIndex,
  output logic        effOverlayPriv,
  output logic        effOverlayUnpriv,
  output logic        effIndirectPerm,
  output logic        effProtAttr,
  output logic        overlayTouched
);
  xctlStrobes_t strb;
  logic [1:0]   curOvl;
  logic [1:0]   nextOvl;

  xctl_ctrl #(.HAS_WIDE(HAS_WIDE)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wideReq(wrData[POS_WIDE]),
    .curOvl(curOvl), .nextOvl(nextOvl), .strb(strb),
    .overlayTouched(overlayTouched)
  );

  xctl_datapath #(
    .HAS_WIDE(HAS_WIDE), .HAS_HWAF(HAS_HWAF), .HAS_COHER(HAS_COHER),
    .COHER_FIXED_ZERO(COHER_FIXED_ZERO), .HAS_ATTR(HAS_ATTR),
    .HAS_OVERLAY(HAS_OVERLAY), .HAS_INDIR(HAS_INDIR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .hypCoherPermit(hypCoherPermit), .stored(rdData),
    .curOvl(curOvl), .nextOvl(nextOvl),
    .effNoContigHi(effNoContigHi), .effNoContigLo(effNoContigLo),
    .effHwAccessTbl(effHwAccessTbl), .effReducedCoher(effReducedCoher),
    .effWideDesc(effWideDesc), .effAttrIndex(effAttrIndex),
    .effOverlayPriv(effOverlayPriv), .effOverlayUnpriv(effOverlayUnpriv),
    .effIndirectPerm(effIndirectPerm), .effProtAttr(effProtAttr)
  );
endmodule

// File: rtl/xctl_checker.sv
module xctl_checker #(
  parameter bit HAS_WIDE         = 1'b1,
  parameter bit HAS_COHER        = 1'b1,
  parameter bit COHER_FIXED_ZERO = 1'b0,
  parameter bit HAS_ATTR         = 1'b1,
  parameter bit HAS_OVERLAY      = 1'b1,
  parameter bit HAS_INDIR        = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  wrOvl,
  input logic [63:0] rdData,
  input logic        hypCoherPermit,
  input logic        effNoContigHi,
  input logic        effNoContigLo,
  input logic        effReducedCoher,
  input logic        overlayTouched
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[63:16] == '0) && (rdData[13:12] == '0) && (rdData[9:6] == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));

  p_wide_forces_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdData[5] |-> ((rdData[4] || !HAS_ATTR) && (rdData[1] || !HAS_INDIR)));

  p_wide_clears_prot_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdData[5] |-> !rdData[0]);

  p_contig_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (effNoContigHi || effNoContigLo) |-> (rdData[5] && HAS_WIDE));

  p_coher_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    effReducedCoher |-> (hypCoherPermit && rdData[10]));

  p_fixed_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (COHER_FIXED_ZERO || !HAS_COHER) |-> !rdData[10]);

  p_overlay_mark_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && HAS_OVERLAY && (wrOvl != rdData[3:2])) |=> overlayTouched);

  p_overlay_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !overlayTouched);
endmodule

bind xlat_ctl2_reg xctl_checker #(
  .HAS_WIDE(HAS_WIDE), .HAS_COHER(HAS_COHER),
  .COHER_FIXED_ZERO(COHER_FIXED_ZERO), .HAS_ATTR(HAS_ATTR),
  .HAS_OVERLAY(HAS_OVERLAY), .HAS_INDIR(HAS_INDIR)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrOvl(wrData[3:2]),
  .rdData(rdData), .hypCoherPermit(hypCoherPermit),
  .effNoContigHi(effNoContigHi), .effNoContigLo(effNoContigLo),
  .effReducedCoher(effReducedCoher), .overlayTouched(overlayTouched)
);

// File: tb/xlat_ctl2_reg_tb_top.sv
module xlat_ctl2_reg_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic        hyp = 1'b0;

  logic [63:0] rdA, rdB;
  logic nchHiA, nchLoA, hwafA, cohA, wideA, attrA, ovpA, ovuA, indA, protA, markA;
  logic nchHiB, nchLoB, hwafB, cohB, wideB, attrB, ovpB, ovuB, indB, protB, markB;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [63:0] rdMain;
    logic        markMain;
    logic [63:0] rdLite;
  } expItem_t;
  expItem_t expQ[$];

  logic [63:0] modelMain = '0;
  logic [63:0] modelLite = '0;
  logic [63:0] lastData = '0;

  always #5 clk = ~clk;

  xlat_ctl2_reg dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .hypCoherPermit(hyp),
    .rdData(rdA), .effNoContigHi(nchHiA), .effNoContigLo(nchLoA),
    .effHwAccessTbl(hwafA), .effReducedCoher(cohA), .effWideDesc(wideA),
    .effAttrIndex(attrA), .effOverlayPriv(ovpA), .effOverlayUnpriv(ovuA),
    .effIndirectPerm(indA), .effProtAttr(protA), .overlayTouched(markA)
  );

  // Reduced instance: no wide format, no overlay, bit 10 fixed at zero
  xlat_ctl2_reg #(.HAS_WIDE(1'b0), .HAS_OVERLAY(1'b0), .COHER_FIXED_ZERO(1'b1)) dut_lite_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .hypCoherPermit(hyp),
    .rdData(rdB), .effNoContigHi(nchHiB), .effNoContigLo(nchLoB),
    .effHwAccessTbl(hwafB), .effReducedCoher(cohB), .effWideDesc(wideB),
    .effAttrIndex(attrB), .effOverlayPriv(ovpB), .effOverlayUnpriv(ovuB),
    .effIndirectPerm(indB), .effProtAttr(protB), .overlayTouched(markB)
  );

  function automatic logic [63:0] clean(input logic [63:0] w, input bit hasWide,
                                        input bit coherRw, input bit hasOvl);
    logic [63:0] r = '0;
    bit wideOn = hasWide && w[5];
    r[15] = hasWide & w[15];
    r[14] = hasWide & w[14];
    r[5]  = wideOn;
    r[11] = w[11];
    r[10] = coherRw & w[10];
    r[4]  = wideOn | w[4];
    r[1]  = wideOn | w[1];
    r[0]  = !wideOn & w[0];
    r[3]  = hasOvl & w[3];
    r[2]  = hasOvl & w[2];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one write, expected results pushed to the scoreboard
  task automatic doWrite(input logic [63:0] d);
    expItem_t it;
    logic [63:0] nm;
    @(negedge clk);
    nm = clean(d, 1'b1, 1'b1, 1'b1);
    it.rdMain   = nm;
    it.markMain = (nm[3:2] != modelMain[3:2]);
    it.rdLite   = clean(d, 1'b0, 1'b0, 1'b0);
    modelMain = nm;
    modelLite = it.rdLite;
    lastData  = d;
    expQ.push_back(it);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  // Monitor: compare outputs just after each write edge
  always @(posedge clk) begin
    if (wrEn && rstN) begin
      expItem_t it;
      #2;
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 actual=write expected=none queued");
      end else begin
        it = expQ.pop_front();
        check("R3 R1 R5 R6 main read", rdA, it.rdMain);
        check("R10 marker", {63'b0, markA}, {63'b0, it.markMain});
        check("R9 lite read", rdB, it.rdLite);
      end
    end
  end

  initial begin
    #3000000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 reset read", rdA, 64'h0);
    check("R2 reset effective", {nchHiA, nchLoA, hwafA, cohA, wideA, attrA, ovpA, ovuA, indA, protA, markA}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // All ones: R1 reserved dropped, R5 forced, R6 prot cleared
    doWrite(64'hFFFF_FFFF_FFFF_FFFF);
    check("R1 R5 R6 all-ones", rdA, 64'h0000_0000_0000_CC3E);
    check("R7 contig effective", {62'b0, nchHiA, nchLoA}, 64'h3);
    check("R4 wide effective", {63'b0, wideA}, 64'h1);
    hyp = 1'b0; #1;
    check("R8 permit low", {63'b0, cohA}, 64'h0);
    hyp = 1'b1; #1;
    check("R8 permit high", {63'b0, cohA}, 64'h1);
    check("R9 lite fixed zero", {63'b0, cohB}, 64'h0);
    check("R9 lite all-ones", rdB, 64'h0000_0000_0000_0813);
    check("R11 effective", {61'b0, hwafA, ovpA, ovuA}, 64'h7);

    // R3: hold with no write
    repeat (4) @(negedge clk);
    check("R3 hold", rdA, 64'h0000_0000_0000_CC3E);
    check("R10 quiet", {63'b0, markA}, 64'h0);

    // R7: contiguous bits without wide mode, R6 prot kept
    doWrite(64'h0000_0000_0000_C001);
    check("R7 no wide", {62'b0, nchHiA, nchLoA}, 64'h0);
    check("R6 prot effective", {63'b0, protA}, 64'h1);

    // R5: wide alone forces bits 4 and 1
    doWrite(64'h0000_0000_0000_0020);
    check("R5 wide alone", rdA, 64'h32);
    check("R5 effective", {62'b0, attrA, indA}, 64'h3);

    // R10: overlay set, then same overlay again (no marker), then one bit changes
    doWrite(64'h0000_0000_0000_000C);
    doWrite(64'h0000_0000_0000_080C);
    check("R11 af", {63'b0, hwafA}, 64'h1);
    doWrite(64'h0000_0000_0000_0008);
    check("R11 overlay split", {62'b0, ovpA, ovuA}, 64'h2);
    doWrite(64'h0000_0000_0000_0400);
    check("R8 stored coher", rdA, 64'h400);
    hyp = 1'b0; #1;
    check("R8 permit drop", {63'b0, cohA}, 64'h0);
    // R1: reserved-only write clears everything else
    doWrite(64'hFFFF_FFFF_FFFF_33C0);
    check("R1 reserved only", rdA, 64'h0);
    check("R10 pending", expQ.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule